// File: doc/BRIEF.md
# CAN Message Buffer Transmit Status Controller

This block keeps the 4-bit status code of one CAN message buffer and steps it through the transmit side of its life. Software first fills the buffer's payload, identifier, length and priority. It then writes a status code that asks for a single send, a send followed by automatic answers to remote requests, or a plain wait for a remote request. The protocol core picks the buffer up by pulsing `sched`. Later it reports one outcome: success, failure, or loss to a higher-priority buffer.

While the buffer is on the bus, its code is the request code with bit 0 set (1100→1101, 1110→1111). Any software write made during that window is held back. It only takes effect when the core reports an outcome. A buffer that answers remote requests re-arms by itself: each sent data frame returns it to the waiting code, and each remote request that arrives queues the data again. `tx_req` tells the buffer arbiter that the buffer wants the bus. Three one-cycle strobes feed the interrupt logic.

Top module: `can_txbuf_status`

## Requirements
- R1: After reset, `status` is 1000 (idle), `tx_req` is low and all three strobes are low.
- R2: Writing 1100 sets `status` to 1100 on the next edge. A `sched` pulse in 1100 then moves it to 1101.
- R3: `tx_done` in 1101 moves `status` to 1000 when `frame_remote` is low, or to 0010 (ready to receive the answer) when it is high. `ev_data_sent` pulses for exactly one cycle, aligned with the new status.
- R4: Writing 1110 sets `status` to 1110. A `sched` pulse moves it to 1111, and `tx_done` then moves it to 1010 with a one-cycle `ev_rtr_answered`.
- R5: `rtr_rx` in 1010 moves `status` to 1110 with a one-cycle `ev_rtr_sched`. The data goes out again and the buffer returns to 1010. `rtr_rx` in any other state has no effect.
- R6: Writing 1010 from idle enters 1010 directly. No request is raised.
- R7: `tx_fail` or `tx_preempt` in 1101 or 1111 returns `status` to 1100 or 1110 respectively, and the request is raised again. If `tx_done` and a failure arrive together, `tx_done` wins.
- R8: Writing 1000 in 1100 or 1110 cancels the pending request. `status` becomes 1000.
- R9: A recognised write made in 1101 or 1111 leaves `status` unchanged until an outcome arrives. The held code then replaces the state the outcome would have chosen, so a held 1000 beats a retry.
- R10: A write of any code other than 1000, 1100, 1110 or 1010 is ignored in every state. This includes while it is held during a busy state.
- R11: `tx_req` is high exactly when `status` is 1100 or 1110. `sched` has no effect in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_wr | input | 1 | Software status write strobe |
| cpu_code | input | 4 | Status code written by software |
| frame_remote | input | 1 | Loaded frame is a remote request (from the identifier's remote bit) |
| sched | input | 1 | Core has scheduled this buffer for the bus |
| tx_done | input | 1 | Scheduled transmission succeeded |
| tx_fail | input | 1 | Scheduled transmission failed |
| tx_preempt | input | 1 | Scheduled transmission displaced by a higher-priority buffer |
| rtr_rx | input | 1 | Matching remote frame received for this buffer |
| status | output | 4 | Current buffer status code |
| tx_req | output | 1 | Transmit request to the buffer arbiter |
| ev_data_sent | output | 1 | One-cycle strobe: frame sent from the single-send busy state |
| ev_rtr_answered | output | 1 | One-cycle strobe: remote request answered with data |
| ev_rtr_sched | output | 1 | One-cycle strobe: remote request queued a data answer |

## Verification
The status width is fixed by the code values, so the bench builds the block in its single configuration, with the package constants. In that configuration every reachable code and every input collision is within reach. This covers writes landing in busy states, cancels held across a failed send, unknown codes arriving while a write is held, `tx_done` and `tx_fail` arriving in the same cycle, and remote requests arriving outside the waiting state. Each of these paths is driven and its result checked at the ports.

// File: rtl/can_txbuf_pkg.sv
package can_txbuf_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    ST_IDLE     = 4'b1000,
    ST_REQ      = 4'b1100,
    ST_BUSY_D   = 4'b1101,
    ST_WAIT_RMT = 4'b1010,
    ST_REQ_ANS  = 4'b1110,
    ST_BUSY_ANS = 4'b1111,
    ST_RX_RDY   = 4'b0010
  } txb_state_e;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (c == ST_IDLE) || (c == ST_REQ) ||
           (c == ST_REQ_ANS) || (c == ST_WAIT_RMT);
  endfunction

endpackage

// File: rtl/can_txbuf_hold.sv
module can_txbuf_hold
  import can_txbuf_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         clear,
  input  logic [W-1:0] code_in,
  output logic         vld,
  output logic [W-1:0] code
);
  logic         vld_d;
  logic [W-1:0] code_d;
  logic         code_en;

  always_comb begin
    vld_d   = vld;
    code_en = 1'b0;
    if (clear) begin
      vld_d = 1'b0;
    end else if (capture) begin
      vld_d   = 1'b1;
      code_en = 1'b1;
    end
    code_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
    end else begin
      vld <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (code_en) begin
      code <= code_d;
    end
  end
endmodule

// File: rtl/can_txbuf_next.sv
module can_txbuf_next
  import can_txbuf_pkg::*;
(
  input  txb_state_e         cur,
  input  logic               cpu_wr,
  input  logic [CODE_W-1:0]  cpu_code,
  input  logic               frame_remote,
  input  logic               sched,
  input  logic               tx_done,
  input  logic               tx_fail,
  input  logic               tx_preempt,
  input  logic               rtr_rx,
  input  logic               hold_vld,
  input  logic [CODE_W-1:0]  hold_code,
  output txb_state_e         nxt,
  output logic               hold_cap,
  output logic               hold_clr,
  output logic               sent_d,
  output logic               ans_d,
  output logic               rsch_d
);
  logic       busy;
  logic       outcome;
  logic       wr_ok;
  txb_state_e base;

  always_comb begin
    busy    = (cur == ST_BUSY_D) || (cur == ST_BUSY_ANS);
    outcome = tx_done || tx_fail || tx_preempt;
    wr_ok   = cpu_wr && code_ok(cpu_code);

    base = cur;
    if (tx_done) begin
      if (cur == ST_BUSY_D) base = frame_remote ? ST_RX_RDY : ST_IDLE;
      else                  base = ST_WAIT_RMT;
    end else if (tx_fail || tx_preempt) begin
      base = (cur == ST_BUSY_D) ? ST_REQ : ST_REQ_ANS;
    end

    nxt      = cur;
    hold_cap = 1'b0;
    hold_clr = 1'b0;
    sent_d   = 1'b0;
    ans_d    = 1'b0;
    rsch_d   = 1'b0;

    if (busy) begin
      if (outcome) begin
        hold_clr = 1'b1;
        sent_d   = tx_done && (cur == ST_BUSY_D);
        ans_d    = tx_done && (cur == ST_BUSY_ANS);
        if (wr_ok)         nxt = txb_state_e'(cpu_code);
        else if (hold_vld) nxt = txb_state_e'(hold_code);
        else               nxt = base;
      end else if (wr_ok) begin
        hold_cap = 1'b1;
      end
    end else begin
      hold_clr = 1'b1;
      if (wr_ok) begin
        nxt = txb_state_e'(cpu_code);
      end else if (sched && (cur == ST_REQ)) begin
        nxt = ST_BUSY_D;
      end else if (sched && (cur == ST_REQ_ANS)) begin
        nxt = ST_BUSY_ANS;
      end else if (rtr_rx && (cur == ST_WAIT_RMT)) begin
        nxt    = ST_REQ_ANS;
        rsch_d = 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_txbuf_evt.sv
module can_txbuf_evt #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_d,
  output logic [N-1:0] ev_q
);
  for (genvar g = 0; g < N; g++) begin : g_strobe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q[g] <= 1'b0;
      else        ev_q[g] <= ev_d[g];
    end
  end
endmodule

// File: rtl/can_txbuf_status.sv
module can_txbuf_status
  import can_txbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CODE_W-1:0] cpu_code,
  input  logic              frame_remote,
  input  logic              sched,
  input  logic              tx_done,
  input  logic              tx_fail,
  input  logic              tx_preempt,
  input  logic              rtr_rx,
  output logic [CODE_W-1:0] status,
  output logic              tx_req,
  output logic              ev_data_sent,
  output logic              ev_rtr_answered,
  output logic              ev_rtr_sched
);
  localparam int NEV = 3;

  txb_state_e        st_q, st_d;
  logic              hold_vld, hold_cap, hold_clr;
  logic [CODE_W-1:0] hold_code;
  logic [NEV-1:0]    ev_d, ev_q;

  can_txbuf_next u_next (
    .cur          (st_q),
    .cpu_wr       (cpu_wr),
    .cpu_code     (cpu_code),
    .frame_remote (frame_remote),
    .sched        (sched),
    .tx_done      (tx_done),
    .tx_fail      (tx_fail),
    .tx_preempt   (tx_preempt),
    .rtr_rx       (rtr_rx),
    .hold_vld     (hold_vld),
    .hold_code    (hold_code),
    .nxt          (st_d),
    .hold_cap     (hold_cap),
    .hold_clr     (hold_clr),
    .sent_d       (ev_d[0]),
    .ans_d        (ev_d[1]),
    .rsch_d       (ev_d[2])
  );

  can_txbuf_hold #(.W(CODE_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (hold_cap),
    .clear   (hold_clr),
    .code_in (cpu_code),
    .vld     (hold_vld),
    .code    (hold_code)
  );

  can_txbuf_evt #(.N(NEV)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_d  (ev_d),
    .ev_q  (ev_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign status          = st_q;
  assign tx_req          = (st_q == ST_REQ) || (st_q == ST_REQ_ANS);
  assign ev_data_sent    = ev_q[0];
  assign ev_rtr_answered = ev_q[1];
  assign ev_rtr_sched    = ev_q[2];
endmodule

// File: rtl/can_txbuf_chk.sv
module can_txbuf_chk
  import can_txbuf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic [CODE_W-1:0] cpu_code,
  input logic              frame_remote,
  input logic              sched,
  input logic              tx_done,
  input logic              tx_fail,
  input logic              tx_preempt,
  input logic              rtr_rx,
  input logic [CODE_W-1:0] status,
  input logic              tx_req,
  input logic              ev_data_sent,
  input logic              ev_rtr_answered,
  input logic              ev_rtr_sched,
  input logic              hold_vld
);
  // R2
  sched_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_REQ && sched && !cpu_wr) |=> status == ST_BUSY_D);

  // R4
  ans_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_BUSY_ANS && tx_done && !cpu_wr && !hold_vld)
      |=> (status == ST_WAIT_RMT && ev_rtr_answered));

  // R7
  retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_BUSY_D && !tx_done && (tx_fail || tx_preempt) && !cpu_wr && !hold_vld)
      |=> (status == ST_REQ && tx_req));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == ST_BUSY_D || status == ST_BUSY_ANS) && !tx_done && !tx_fail && !tx_preempt)
      |=> $stable(status));

  // R5
  rtr_sched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rtr_sched |-> (status == ST_REQ_ANS && $past(status) == ST_WAIT_RMT));

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_data_sent, ev_rtr_answered, ev_rtr_sched}));

  // R10
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_IDLE || status == ST_REQ || status == ST_BUSY_D ||
     status == ST_WAIT_RMT || status == ST_REQ_ANS || status == ST_BUSY_ANS ||
     status == ST_RX_RDY));
endmodule

bind can_txbuf_status can_txbuf_chk i_chk (.*);

// File: tb/test_can_txbuf_status.sv
module test_can_txbuf_status;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_wr, frame_remote, sched, tx_done, tx_fail, tx_preempt, rtr_rx;
  logic [3:0] cpu_code;
  logic [3:0] status;
  logic       tx_req, ev_data_sent, ev_rtr_answered, ev_rtr_sched;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_txbuf_status i_can_txbuf_status (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_code(cpu_code),
    .frame_remote(frame_remote), .sched(sched), .tx_done(tx_done),
    .tx_fail(tx_fail), .tx_preempt(tx_preempt), .rtr_rx(rtr_rx),
    .status(status), .tx_req(tx_req), .ev_data_sent(ev_data_sent),
    .ev_rtr_answered(ev_rtr_answered), .ev_rtr_sched(ev_rtr_sched)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one cycle of stimulus, applied at a falling edge, removed at the next
  task automatic cyc(input logic w, input logic [3:0] c, input logic s,
                     input logic d, input logic f, input logic p, input logic r);
    cpu_wr = w; cpu_code = c; sched = s; tx_done = d;
    tx_fail = f; tx_preempt = p; rtr_rx = r;
    @(negedge clk);
    cpu_wr = 0; sched = 0; tx_done = 0; tx_fail = 0; tx_preempt = 0; rtr_rx = 0;
  endtask

  task automatic wr(input logic [3:0] c); cyc(1, c, 0, 0, 0, 0, 0); endtask
  task automatic idle();                  cyc(0, 4'h0, 0, 0, 0, 0, 0); endtask

  task automatic t_reset();
    chk("R1 status", status, 4'b1000);
    chk("R1 tx_req", {3'b0, tx_req}, 4'd0);
    chk("R1 strobes", {1'b0, ev_data_sent, ev_rtr_answered, ev_rtr_sched}, 4'd0);
  endtask

  task automatic t_single();
    frame_remote = 0;
    wr(4'b1100);
    chk("R2 req", status, 4'b1100);
    chk("R11 req high", {3'b0, tx_req}, 4'd1);
    cyc(0, 0, 1, 0, 0, 0, 0);
    chk("R2 busy", status, 4'b1101);
    chk("R11 req low busy", {3'b0, tx_req}, 4'd0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R3 idle", status, 4'b1000);
    chk("R3 strobe", {3'b0, ev_data_sent}, 4'd1);
    idle();
    chk("R3 strobe one cycle", {3'b0, ev_data_sent}, 4'd0);
  endtask

  task automatic t_remote_frame();
    frame_remote = 1;
    wr(4'b1100);
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R3 rx ready", status, 4'b0010);
    frame_remote = 0;
    cyc(0, 0, 1, 0, 0, 0, 0);
    chk("R11 sched ignored", status, 4'b0010);
    wr(4'b1000);
  endtask

  task automatic t_retry();
    wr(4'b1100);
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R7 fail", status, 4'b1100);
    chk("R7 req again", {3'b0, tx_req}, 4'd1);
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R7 preempt", status, 4'b1100);
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    chk("R7 done wins", status, 4'b1000);
  endtask

  task automatic t_answer();
    wr(4'b1110);
    chk("R4 req", status, 4'b1110);
    cyc(0, 0, 1, 0, 0, 0, 0);
    chk("R4 busy", status, 4'b1111);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R7 preempt ans", status, 4'b1110);
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R4 wait", status, 4'b1010);
    chk("R4 strobe", {3'b0, ev_rtr_answered}, 4'd1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R5 queued", status, 4'b1110);
    chk("R5 strobe", {3'b0, ev_rtr_sched}, 4'd1);
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R5 back to wait", status, 4'b1010);
    wr(4'b1000);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R5 rtr ignored idle", status, 4'b1000);
    chk("R5 no strobe idle", {3'b0, ev_rtr_sched}, 4'd0);
  endtask

  task automatic t_direct_wait();
    wr(4'b1010);
    chk("R6 wait", status, 4'b1010);
    chk("R6 no req", {3'b0, tx_req}, 4'd0);
    wr(4'b1000);
  endtask

  task automatic t_cancel();
    wr(4'b1100);
    wr(4'b1000);
    chk("R8 cancel", status, 4'b1000);
    wr(4'b1110);
    wr(4'b1000);
    chk("R8 cancel ans", status, 4'b1000);
  endtask

  task automatic t_held();
    wr(4'b1100);
    cyc(0, 0, 1, 0, 0, 0, 0);
    wr(4'b1000);
    chk("R9 held busy", status, 4'b1101);
    idle();
    chk("R9 still busy", status, 4'b1101);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R9 cancel beats retry", status, 4'b1000);
    wr(4'b1110);
    cyc(0, 0, 1, 0, 0, 0, 0);
    wr(4'b1010);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R9 held replaces", status, 4'b1010);
    wr(4'b1000);
  endtask

  task automatic t_unknown();
    wr(4'b0111);
    chk("R10 idle unknown", status, 4'b1000);
    wr(4'b1101);
    chk("R10 busy code write", status, 4'b1000);
    wr(4'b1100);
    cyc(0, 0, 1, 0, 0, 0, 0);
    wr(4'b0001);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R10 held unknown", status, 4'b1100);
    wr(4'b1000);
  endtask

  initial begin
    rst_n = 0; cpu_wr = 0; cpu_code = 0; frame_remote = 0; sched = 0;
    tx_done = 0; tx_fail = 0; tx_preempt = 0; rtr_rx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_remote_frame();
    t_retry();
    t_answer();
    t_direct_wait();
    t_cancel();
    t_held();
    t_unknown();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule